// File: doc/BRIEF.md
# Baseband Register Write-Verify Controller

This controller owns the single command port into a baseband processor's register file. A host request names a register address, a data byte and a direction. A write is sent as a write command word and then confirmed. A readback command word for the same address follows at once. After a verify wait the returned byte is compared with the intended value. On a mismatch the controller waits for a retry gap and repeats the write-plus-readback pair. It stops on a match, or after a fixed budget of attempts, in which case it reports a timeout.

A read issues only the readback command word, waits a longer settling time, then captures the returned byte. All waits are whole microseconds, counted by a prescaled tick counter driven by the core clock. The request side is a valid/ready handshake. Completion is a one-cycle pulse carrying the timeout flag, the last byte seen on the read-data lines and the number of write attempts used.

States: `ST_IDLE` (ready for a request), `ST_WR_CMD` (write word on the port), `ST_RB_CMD` (readback word on the port), `ST_VERIFY_WAIT` (verify wait, then compare), `ST_RETRY_WAIT` (gap before the next attempt), `ST_RD_CMD` (read word on the port), `ST_RD_WAIT` (settling wait, then capture) and `ST_FINISH` (done pulse). The transitions are:
- `ST_IDLE` to `ST_WR_CMD` or to `ST_RD_CMD` when a request is accepted.
- `ST_WR_CMD` to `ST_RB_CMD`, then `ST_RB_CMD` to `ST_VERIFY_WAIT`.
- At the end of `ST_VERIFY_WAIT`, to `ST_FINISH` on a match or when the budget is spent, otherwise to `ST_RETRY_WAIT`.
- `ST_RETRY_WAIT` to `ST_WR_CMD` when its wait ends.
- `ST_RD_CMD` to `ST_RD_WAIT`, then `ST_RD_WAIT` to `ST_FINISH` when its wait ends.
- `ST_FINISH` to `ST_IDLE`.

Top module: `bbreg_wv_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` pulses while the controller is busy have no effect on the port or on any register contents.
- R2: In the cycle after a write is accepted, and in the first cycle of every retry attempt, `bb_strobe`=1 and `bb_wen`=1. In that cycle `bb_addr` carries the request address and `bb_wdata` carries the request data.
- R3: The cycle after every write command word carries the readback word: `bb_strobe`=1, `bb_wen`=0, the same address, and `bb_wdata` all ones.
- R4: After the readback word, the controller waits VERIFY_US×TICKS_PER_US cycles (N) and then compares `bb_rdata` with the request data. On a match, `done` rises 2+N cycles after the acceptance cycle of the final attempt. In that cycle `done_timeout`=0, `done_rdata` equals the data, and `done_attempts` equals the number of attempts used (1 for a first-time match).
- R5: On a mismatch with budget left, the controller idles the port for RETRY_US×TICKS_PER_US cycles (M) and then reissues the write word. Attempts therefore start every 2+N+M cycles.
- R6: If attempt MAX_ATTEMPTS also mismatches, `done` pulses at once with `done_timeout`=1, `done_attempts`=MAX_ATTEMPTS and `done_rdata` equal to the last returned byte. No further command word is issued.
- R7: A read puts a readback-style word (`bb_wen`=0, `bb_wdata` all ones) on the port in the cycle after acceptance. It then waits READ_US×TICKS_PER_US cycles (K) and captures `bb_rdata`. `done` rises 1+K cycles after acceptance, with `done_timeout`=0 and `done_attempts`=0.
- R8: `done` is high for exactly one cycle per request, and `bb_strobe` is low in every cycle other than those named in R2, R3 and R7.
- R9: After reset, `req_ready`=1 and `done`=0, `bb_strobe`=0 and `done_timeout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = verified write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_data | input | DATA_W | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| done_timeout | output | 1 | Write never matched within the budget |
| done_rdata | output | DATA_W | Captured or last compared byte |
| done_attempts | output | clog2(MAX_ATTEMPTS+1) | Write attempts used, 0 for reads |
| bb_strobe | output | 1 | Command word valid on the port this cycle |
| bb_wen | output | 1 | Write-enable bit of the command word |
| bb_addr | output | ADDR_W | Address field of the command word |
| bb_wdata | output | DATA_W | Write-data field, all ones when not writing |
| bb_rdata | input | DATA_W | Byte returned by the baseband |

## Verification
The cycle offsets are counted from the cycle after acceptance (offset 0):
- A write attempt k, counted from 0, puts its write word at offset k(2+N+M) and its readback word one cycle later.
- A write's `done` lands at f(2+N+M)+2+N, where f is the index of the final attempt.
- A read's `done` lands at 1+K.

The bench's behavioural model tracks that offset with an integer after every edge. Each falling edge then compares `req_ready`, `done` and `bb_strobe` with the model. At every offset where a strobe is due it also compares the command fields, and at the `done` offset it compares the three result fields. The baseband stub can be told to drop a given number of writes and has one read-only address. With it, retries, the exact budget boundary and the timeout can each be placed at a known offset.

// File: rtl/bbwv_pkg.sv
package bbwv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_CMD,
        ST_RB_CMD,
        ST_VERIFY_WAIT,
        ST_RETRY_WAIT,
        ST_RD_CMD,
        ST_RD_WAIT,
        ST_FINISH
    } ctrl_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_WRITE,
        CMD_READBACK
    } bb_cmd_e;

endpackage

// File: rtl/bbwv_us_timer.sv
module bbwv_us_timer #(
    parameter int TICKS_PER_US = 100,
    parameter int LOAD_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LOAD_W-1:0] load_us,
    output logic              expire,
    output logic              running
);
    localparam int PRE_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;

    logic [LOAD_W-1:0] rem_q;
    logic              run_q;
    logic              us_tick;

    generate
        if (TICKS_PER_US > 1) begin : g_prescale
            logic [PRE_W-1:0] pre_q;
            assign us_tick = run_q && (pre_q == PRE_W'(TICKS_PER_US - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (start || us_tick) begin
                    pre_q <= '0;
                end else if (run_q) begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end else begin : g_direct
            assign us_tick = run_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            rem_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            rem_q <= load_us;
        end else if (us_tick) begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == LOAD_W'(1)) begin
                run_q <= 1'b0;
            end
        end
    end

    assign expire  = us_tick && (rem_q == LOAD_W'(1));
    assign running = run_q;

    // R4: a wait must be at least one microsecond long
    a_r4_nonzero_load: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (load_us != '0));

    // R4: the loaded count is the one requested
    a_r4_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (run_q && rem_q == $past(load_us)));

endmodule

// File: rtl/bbwv_attempt_ctr.sv
module bbwv_attempt_ctr #(
    parameter int MAX_ATTEMPTS = 50,
    localparam int CNT_W       = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    output logic [CNT_W-1:0] count,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (bump) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
    assign last  = (cnt_q == CNT_W'(MAX_ATTEMPTS));

    // R6: no attempt is started once the budget is spent
    a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        bump |-> (cnt_q < CNT_W'(MAX_ATTEMPTS)));

endmodule

// File: rtl/bbwv_cmd_fmt.sv
module bbwv_cmd_fmt
    import bbwv_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  bb_cmd_e            cmd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  data,
    output logic               strobe,
    output logic               wen,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [DATA_W-1:0]  cmd_wdata
);
    always_comb begin
        cmd_addr = addr;
        unique case (cmd)
            CMD_WRITE: begin
                strobe    = 1'b1;
                wen       = 1'b1;
                cmd_wdata = data;
            end
            CMD_READBACK: begin
                strobe    = 1'b1;
                wen       = 1'b0;
                cmd_wdata = '1;
            end
            default: begin
                strobe    = 1'b0;
                wen       = 1'b0;
                cmd_wdata = '1;
            end
        endcase
    end

endmodule

// File: rtl/bbreg_wv_ctrl.sv
module bbreg_wv_ctrl
    import bbwv_pkg::*;
#(
    parameter int ADDR_W       = 7,
    parameter int DATA_W       = 8,
    parameter int TICKS_PER_US = 100,
    parameter int VERIFY_US    = 1,
    parameter int RETRY_US     = 1,
    parameter int READ_US      = 10,
    parameter int MAX_ATTEMPTS = 50
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    output logic                               req_ready,
    input  logic                               req_write,
    input  logic [ADDR_W-1:0]                  req_addr,
    input  logic [DATA_W-1:0]                  req_data,
    output logic                               done,
    output logic                               done_timeout,
    output logic [DATA_W-1:0]                  done_rdata,
    output logic [$clog2(MAX_ATTEMPTS+1)-1:0]  done_attempts,
    output logic                               bb_strobe,
    output logic                               bb_wen,
    output logic [ADDR_W-1:0]                  bb_addr,
    output logic [DATA_W-1:0]                  bb_wdata,
    input  logic [DATA_W-1:0]                  bb_rdata
);
    localparam int CNT_W  = $clog2(MAX_ATTEMPTS + 1);
    localparam int US_MAX = (READ_US > VERIFY_US)
                          ? ((READ_US > RETRY_US) ? READ_US : RETRY_US)
                          : ((VERIFY_US > RETRY_US) ? VERIFY_US : RETRY_US);
    localparam int LOAD_W = $clog2(US_MAX + 1);

    ctrl_state_e       state_q, state_d;
    bb_cmd_e           cmd;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              write_q;
    logic              accept;
    logic              tmr_start;
    logic [LOAD_W-1:0] tmr_load;
    logic              tmr_expire;
    logic              tmr_running;
    logic [CNT_W-1:0]  att_count;
    logic              att_last;
    logic              mismatch;
    logic              finish_set;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign mismatch = (bb_rdata != data_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and timer control
    always_comb begin
        state_d   = state_q;
        tmr_start = 1'b0;
        tmr_load  = LOAD_W'(VERIFY_US);
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = req_write ? ST_WR_CMD : ST_RD_CMD;
                end
            end
            ST_WR_CMD: begin
                state_d = ST_RB_CMD;
            end
            ST_RB_CMD: begin
                state_d   = ST_VERIFY_WAIT;
                tmr_start = 1'b1;
                tmr_load  = LOAD_W'(VERIFY_US);
            end
            ST_VERIFY_WAIT: begin
                if (tmr_expire) begin
                    if (!mismatch || att_last) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d   = ST_RETRY_WAIT;
                        tmr_start = 1'b1;
                        tmr_load  = LOAD_W'(RETRY_US);
                    end
                end
            end
            ST_RETRY_WAIT: begin
                if (tmr_expire) begin
                    state_d = ST_WR_CMD;
                end
            end
            ST_RD_CMD: begin
                state_d   = ST_RD_WAIT;
                tmr_start = 1'b1;
                tmr_load  = LOAD_W'(READ_US);
            end
            ST_RD_WAIT: begin
                if (tmr_expire) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign finish_set = (state_d == ST_FINISH) && (state_q != ST_FINISH);

    // outputs and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q        <= '0;
            data_q        <= '0;
            write_q       <= 1'b0;
            done_timeout  <= 1'b0;
            done_rdata    <= '0;
            done_attempts <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                data_q  <= req_data;
                write_q <= req_write;
            end
            if (finish_set) begin
                done_timeout  <= write_q && mismatch;
                done_rdata    <= bb_rdata;
                done_attempts <= write_q ? att_count : '0;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_WR_CMD:            cmd = CMD_WRITE;
            ST_RB_CMD, ST_RD_CMD: cmd = CMD_READBACK;
            default:              cmd = CMD_NONE;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign done      = (state_q == ST_FINISH);

    bbwv_us_timer #(
        .TICKS_PER_US (TICKS_PER_US),
        .LOAD_W       (LOAD_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .load_us (tmr_load),
        .expire  (tmr_expire),
        .running (tmr_running)
    );

    bbwv_attempt_ctr #(
        .MAX_ATTEMPTS (MAX_ATTEMPTS)
    ) u_attempts (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .bump  (state_q == ST_WR_CMD),
        .count (att_count),
        .last  (att_last)
    );

    bbwv_cmd_fmt #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fmt (
        .cmd       (cmd),
        .addr      (addr_q),
        .data      (data_q),
        .strobe    (bb_strobe),
        .wen       (bb_wen),
        .cmd_addr  (bb_addr),
        .cmd_wdata (bb_wdata)
    );

    // R1: an accepted request makes the controller busy
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3: a write word is always followed by a readback of the same address
    a_r3_readback_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_strobe && bb_wen) |=> (bb_strobe && !bb_wen && bb_addr == $past(bb_addr)));

    // R5: the end of a retry gap reissues the write word
    a_r5_retry_rewrites: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETRY_WAIT && tmr_expire) |=> (bb_strobe && bb_wen));

    // R4: waiting states are always backed by a running timer
    a_r4_wait_timed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VERIFY_WAIT || state_q == ST_RETRY_WAIT || state_q == ST_RD_WAIT)
        |-> tmr_running);

    // R8: completion is a single-cycle pulse
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/tb_bbreg_wv_ctrl.sv
module tb_bbreg_wv_ctrl;
    localparam int AW    = 7;
    localparam int DW    = 8;
    localparam int TPU   = 4;
    localparam int V_US  = 1;
    localparam int RT_US = 1;
    localparam int RD_US = 10;
    localparam int MAXA  = 50;
    localparam int NV    = V_US * TPU;
    localparam int NRT   = RT_US * TPU;
    localparam int NRD   = RD_US * TPU;
    localparam int LEN   = 2 + NV + NRT;
    localparam int RO_ADDR = 'h33;
    localparam int RO_VAL  = 'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic req_ready, done, done_timeout, bb_strobe, bb_wen;
    logic [DW-1:0] done_rdata, bb_wdata;
    logic [DW-1:0] bb_rdata;
    logic [5:0] done_attempts;
    logic [AW-1:0] bb_addr;

    always #2 clk = ~clk;

    bbreg_wv_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .TICKS_PER_US(TPU), .VERIFY_US(V_US),
        .RETRY_US(RT_US), .READ_US(RD_US), .MAX_ATTEMPTS(MAXA)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
        .done(done), .done_timeout(done_timeout), .done_rdata(done_rdata),
        .done_attempts(done_attempts), .bb_strobe(bb_strobe), .bb_wen(bb_wen),
        .bb_addr(bb_addr), .bb_wdata(bb_wdata), .bb_rdata(bb_rdata)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // baseband stub: register file, one read-only address, programmable dropped writes
    logic [DW-1:0] stub_mem [0:(1<<AW)-1];
    int drop_cfg = 0;
    int drops_done;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < (1<<AW); i++) stub_mem[i] <= '0;
            bb_rdata   <= '0;
            drops_done <= 0;
        end else begin
            if (req_valid && req_ready) drops_done <= 0;
            if (bb_strobe && bb_wen) begin
                if (drops_done < drop_cfg) drops_done <= drops_done + 1;
                else if (int'(bb_addr) != RO_ADDR) stub_mem[bb_addr] <= bb_wdata;
            end
            if (bb_strobe && !bb_wen)
                bb_rdata <= (int'(bb_addr) == RO_ADDR) ? DW'(RO_VAL) : stub_mem[bb_addr];
        end
    end

    // behavioural reference: offset since acceptance
    int  e_f = 0;
    bit  e_timeout = 0;
    int  e_rdata = 0;
    bit  m_busy = 0;
    int  m_off = 0;
    int  m_dl = 0;
    bit  m_write = 0;
    int  m_addr = 0, m_data = 0, m_f = 0, m_rdata = 0;
    bit  m_timeout = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0;
        end else if (!m_busy) begin
            if (req_valid) begin
                m_busy    = 1;
                m_off     = 0;
                m_write   = req_write;
                m_addr    = int'(req_addr);
                m_data    = int'(req_data);
                m_f       = e_f;
                m_timeout = e_timeout;
                m_rdata   = e_rdata;
                m_dl      = req_write ? (e_f * LEN + 2 + NV) : (1 + NRD);
            end
        end else if (m_off == m_dl) begin
            m_busy = 0;
        end else begin
            m_off++;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit es, ew, ed;
            int ewd;
            es = 0; ew = 0; ed = 0; ewd = 'hFF;
            if (m_busy) begin
                ed = (m_off == m_dl);
                if (m_write) begin
                    if (m_off < m_dl) begin
                        es  = (m_off % LEN) < 2;
                        ew  = (m_off % LEN) == 0;
                        ewd = ew ? m_data : 'hFF;
                    end
                end else begin
                    es = (m_off == 0);
                end
            end
            chk(req_ready == !m_busy, "R1", "req_ready", req_ready, !m_busy);
            chk(done == ed, "R8", "done", done, ed);
            chk(bb_strobe == es, "R8", "bb_strobe", bb_strobe, es);
            if (es) begin
                chk(bb_wen == ew, ew ? "R2" : (m_write ? "R3" : "R7"), "bb_wen", bb_wen, ew);
                chk(int'(bb_addr) == m_addr, ew ? "R2" : "R3", "bb_addr", bb_addr, m_addr);
                chk(int'(bb_wdata) == ewd, ew ? "R2" : "R3", "bb_wdata", bb_wdata, ewd);
                if (m_write && m_off >= LEN && ew)
                    chk(1'b1, "R5", "retry write", 1, 1);
            end
            if (ed) begin
                chk(done_timeout == m_timeout, m_timeout ? "R6" : "R4", "done_timeout",
                    done_timeout, m_timeout);
                chk(int'(done_rdata) == m_rdata, m_write ? "R4" : "R7", "done_rdata",
                    done_rdata, m_rdata);
                chk(int'(done_attempts) == (m_write ? m_f + 1 : 0),
                    m_write ? "R6" : "R7", "done_attempts", done_attempts,
                    m_write ? m_f + 1 : 0);
            end
        end
    end

    int shadow [0:(1<<AW)-1];

    task automatic launch(input bit wr, input int a, input int d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_data  = DW'(d);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input int a, input int d, input int drops, input bit poke_busy);
        bit ro;
        ro = (a == RO_ADDR);
        drop_cfg  = drops;
        e_timeout = ro ? (d != RO_VAL) : 1'b0;
        e_f       = ro ? ((d == RO_VAL) ? 0 : MAXA - 1) : drops;
        e_rdata   = ro ? RO_VAL : d;
        if (!ro) shadow[a] = d;
        launch(1'b1, a, d);
        if (poke_busy) begin
            // R1: a request while busy must not be taken
            @(negedge clk);
            req_valid = 1'b1;
            req_write = 1'b1;
            req_addr  = AW'('h21);
            req_data  = DW'('hEE);
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        wait_idle();
    endtask

    task automatic do_read(input int a);
        drop_cfg  = 0;
        e_f       = 0;
        e_timeout = 1'b0;
        e_rdata   = (a == RO_ADDR) ? RO_VAL : shadow[a];
        launch(1'b0, a, 'h00);
        wait_idle();
    endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) shadow[i] = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(req_ready == 1'b1, "R9", "req_ready", req_ready, 1);
        chk(done == 1'b0, "R9", "done", done, 0);
        chk(bb_strobe == 1'b0, "R9", "bb_strobe", bb_strobe, 0);
        chk(done_timeout == 1'b0, "R9", "done_timeout", done_timeout, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_write('h05, 'hC3, 0, 1'b0);      // R4 first-time match
        do_read('h05);                      // R7 read back
        do_write('h10, 'hFF, 3, 1'b0);      // R5 three retries, all-ones data
        do_write(RO_ADDR, 'h11, 0, 1'b0);   // R6 timeout
        do_write(RO_ADDR, RO_VAL, 0, 1'b0); // R4 match on read-only value
        do_write('h20, 'h77, 0, 1'b1);      // R1 busy request ignored
        do_read('h21);                      // R1 untouched register
        do_read('h20);
        do_write('h7F, 'h01, MAXA - 1, 1'b0); // R6 match on the very last attempt
        do_read('h7F);
        do_read(RO_ADDR);                   // R7
        do_read('h00);                      // R7 never written

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule